// File: doc/BRIEF.md
# Timer-Paced Double-Buffered DAC Feeder

This peripheral drives a set of 8-bit DAC channels (two by default, left and right) at a fixed sample rate, so that how quickly the processor answers an interrupt has no effect on the output. Each channel has two registers. The processor writes the next sample into a staging register. A separate output register drives the DAC pins. A programmable interval timer copies every staging register into its output register on the same clock edge, and on that edge it also raises an interrupt.

The processor answers that interrupt at its own pace. It only has to load the next samples before the following tick, so its response time may be as long as one sample period. To start a sequence, software preloads the first samples and then starts the timer. After the last samples have been written, one more tick moves them to the DAC, and at that interrupt software stops the timer.

The register bus is a plain address/strobe interface with combinational read data. An interrupt line and the parallel DAC words are the only other outputs.

Top module: `dac_dblbuf`

## Requirements
- R1: After reset, all DAC outputs are 0, `irq` is low, and the control/status register (address 0) and the divisor register (address 1) both read 0.
- R2: While the run bit (address 0, bit 0) is set and the divisor is N≥1, the first tick latches N clock edges after the edge that set the run bit. Ticks then repeat every N edges. While the run bit is clear, no ticks occur and the count is held at its start value.
- R3: On a tick, every channel's output register takes its staging register's value on the same edge. `dacOut` packs channel k into bits [8k+7:8k].
- R4: A staging write does not change `dacOut`. Between ticks, `dacOut` is stable.
- R5: A tick sets the pending bit (address 0, bit 3, read-only). `irq` equals pending AND interrupt-enable (address 0, bit 1). With the enable clear, the pending bit still sets, and `irq` rises as soon as the enable is set.
- R6: A read strobe at address 2 clears the pending bit. If a tick falls on the same edge, pending stays set.
- R7: If a tick occurs while any channel has not been written since the previous tick (or since reset), the underrun bit (address 0, bit 2) sets, and that channel's old value is copied to the output again. Writing 1 to bit 2 clears the bit. Writing 0 to it leaves the bit unchanged.
- R8: Register map. Address 0 holds run (bit 0) and interrupt-enable (bit 1), both read/write. Address 1 is the 16-bit divisor, read/write. Address 4+k is the staging register of channel k; writes use data bits [7:0], and a read returns the staged value.
- R9: A staging write on the same edge as a tick does not reach the output on that tick. The output takes the previous staged value. The new value counts as fresh for the next tick, and is output then.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (side effect only at address 2) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Combinational read data |
| irq | output | 1 | Interrupt request |
| dacOut | output | 16 | Output registers, channel k in bits [8k+7:8k] |

## Verification
The assertions check the following on every cycle:
- every tick copies each staging register into its output register;
- the outputs hold between ticks;
- a tick always leaves the pending bit set;
- an acknowledge without a coincident tick always clears it;
- a tick with a stale channel always sets the underrun bit;
- ticks are never back to back unless the divisor is 1.

Only the bench scenarios can show the rest:
- the exact distance from starting the timer to the first tick, and between later ticks;
- how a write that lands on the tick edge is ordered against that tick;
- a tick that coincides with an acknowledge;
- masking and unmasking of the interrupt;
- the write-one-to-clear behaviour;
- that the staged samples arrive at the outputs in order.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  localparam int unsigned CH_SEL_W = 3;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_DIV  = 1;
  localparam int unsigned ADDR_ACK  = 2;
  localparam int unsigned ADDR_BUF0 = 4;

  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_IEN  = 1;
  localparam int unsigned BIT_UNDR = 2;
  localparam int unsigned BIT_PEND = 3;

  typedef struct packed {
    logic                tick;
    logic                bufWr;
    logic [CH_SEL_W-1:0] chSel;
  } dp_strobe_t;

endpackage

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [NUM_CH*SAMPLE_W-1:0] bufRd,
  output logic [DATA_W-1:0]          rdData,
  output logic                       irq,
  output dp_strobe_t                 strobe
);

  logic [ADDR_W-1:0] bufOff;
  logic              isBuf;
  logic              ctrlWr;
  logic              divWr;
  logic              ackRd;

  logic              runQ;
  logic              ienQ;
  logic              undrQ;
  logic              pendQ;
  logic [DIV_W-1:0]  divQ;
  logic [DIV_W-1:0]  cntQ;
  logic [NUM_CH-1:0] freshQ;
  logic              tick;

  assign bufOff = addr - ADDR_W'(ADDR_BUF0);
  assign isBuf  = (addr >= ADDR_W'(ADDR_BUF0)) && (bufOff < ADDR_W'(NUM_CH));
  assign ctrlWr = wrEn && (addr == ADDR_W'(ADDR_CTRL));
  assign divWr  = wrEn && (addr == ADDR_W'(ADDR_DIV));
  assign ackRd  = rdEn && (addr == ADDR_W'(ADDR_ACK));

  // sample-rate timer: counts 0..div-1, tick on the last count
  assign tick = runQ && (cntQ == DIV_W'(divQ - 1'b1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (!runQ || tick) begin
      cntQ <= '0;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runQ <= 1'b0;
      ienQ <= 1'b0;
      divQ <= '0;
    end else begin
      if (ctrlWr) begin
        runQ <= wrData[BIT_RUN];
        ienQ <= wrData[BIT_IEN];
      end
      if (divWr) begin
        divQ <= wrData[DIV_W-1:0];
      end
    end
  end

  // per-channel freshness: written since the last tick
  for (genvar g = 0; g < NUM_CH; g++) begin : gFresh
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        freshQ[g] <= 1'b0;
      end else if (wrEn && isBuf && (bufOff == ADDR_W'(g))) begin
        freshQ[g] <= 1'b1;
      end else if (tick) begin
        freshQ[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      undrQ <= 1'b0;
    end else if (tick && !(&freshQ)) begin
      undrQ <= 1'b1;
    end else if (ctrlWr && wrData[BIT_UNDR]) begin
      undrQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= 1'b0;
    end else if (tick) begin
      pendQ <= 1'b1;
    end else if (ackRd) begin
      pendQ <= 1'b0;
    end
  end

  assign irq = pendQ && ienQ;

  assign strobe.tick  = tick;
  assign strobe.bufWr = wrEn && isBuf;
  assign strobe.chSel = CH_SEL_W'(bufOff);

  always_comb begin
    rdData = '0;
    if (addr == ADDR_W'(ADDR_CTRL)) begin
      rdData[BIT_RUN]  = runQ;
      rdData[BIT_IEN]  = ienQ;
      rdData[BIT_UNDR] = undrQ;
      rdData[BIT_PEND] = pendQ;
    end else if (addr == ADDR_W'(ADDR_DIV)) begin
      rdData = DATA_W'(divQ);
    end else if (isBuf) begin
      rdData = DATA_W'(bufRd[int'(bufOff)*SAMPLE_W +: SAMPLE_W]);
    end
  end

  AST_PEND_ON_TICK: assert property (@(posedge clk) disable iff (!rstN)
    tick |=> pendQ); // R5

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (ackRd && !tick) |=> !pendQ); // R6

  AST_UNDERRUN_SETS: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !(&freshQ)) |=> undrQ); // R7

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !divWr && (divQ != DIV_W'(1))) |=> !tick); // R2

endmodule

// File: rtl/dacif_datapath.sv
module dacif_datapath
  import dacif_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  dp_strobe_t                 strobe,
  input  logic [DATA_W-1:0]          wrData,
  output logic [NUM_CH*SAMPLE_W-1:0] bufRd,
  output logic [NUM_CH*SAMPLE_W-1:0] dacOut
);

  logic [SAMPLE_W-1:0] stageQ [NUM_CH];
  logic [SAMPLE_W-1:0] outQ   [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageQ[g] <= '0;
      end else if (strobe.bufWr && (strobe.chSel == CH_SEL_W'(g))) begin
        stageQ[g] <= wrData[SAMPLE_W-1:0];
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outQ[g] <= '0;
      end else if (strobe.tick) begin
        outQ[g] <= stageQ[g];
      end
    end

    assign bufRd[g*SAMPLE_W +: SAMPLE_W]  = stageQ[g];
    assign dacOut[g*SAMPLE_W +: SAMPLE_W] = outQ[g];

    AST_LATCH_FROM_STAGE: assert property (@(posedge clk) disable iff (!rstN)
      strobe.tick |=> (outQ[g] == $past(stageQ[g]))); // R3

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.tick |=> $stable(outQ[g])); // R4
  end

endmodule

// File: rtl/dac_dblbuf.sv
module dac_dblbuf
  import dacif_pkg::*;
#(
  parameter int unsigned NUM_CH   = 2,
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned ADDR_W   = 3,
  parameter int unsigned DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [DATA_W-1:0]          wrData,
  output logic [DATA_W-1:0]          rdData,
  output logic                       irq,
  output logic [NUM_CH*SAMPLE_W-1:0] dacOut
);

  dp_strobe_t                 strobe;
  logic [NUM_CH*SAMPLE_W-1:0] bufRd;

  dacif_ctrl #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .bufRd(bufRd), .rdData(rdData), .irq(irq),
    .strobe(strobe)
  );

  dacif_datapath #(
    .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DATA_W(DATA_W)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .bufRd(bufRd), .dacOut(dacOut)
  );

endmodule

// File: tb/dac_dblbuf_test.sv
`timescale 1ns/1ps
module dac_dblbuf_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        irq;
  logic [15:0] dacOut;

  int vecs = 0;
  int miss = 0;
  int cyc = 0;
  int irqCount = 0;
  int lastIrqCyc = 0;
  logic irqPrev = 1'b0;
  logic [15:0] sbq [$];

  dac_dblbuf uut (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .dacOut(dacOut)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: each rising irq pops the next expected output pair
  always @(negedge clk) begin
    if (rstN && irq && !irqPrev) begin
      irqCount++;
      lastIrqCyc = cyc;
      if (sbq.size() == 0) chk("R5 irq with empty scoreboard", 1, 0);
      else chk("R3 scoreboard dacOut", {16'h0, dacOut}, {16'h0, sbq.pop_front()});
    end
    irqPrev = irq;
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic waitIrq();
    int n0 = irqCount;
    int k = 0;
    while (irqCount == n0 && k < 300) begin
      @(negedge clk); #1; k++;
    end
    if (irqCount == n0) chk("R2 irq timeout", 1, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miss++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    logic [15:0] v;
    int wrEdge;
    int tickRef;
    int x;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 dacOut reset", {16'h0, dacOut}, 0);
    chk("R1 irq reset", {31'h0, irq}, 0);
    rd(3'd0, v); chk("R1 ctrl reset", {16'h0, v}, 0);
    rd(3'd1, v); chk("R1 div reset", {16'h0, v}, 0);

    wr(3'd1, 16'd20);
    rd(3'd1, v); chk("R8 div readback", {16'h0, v}, 20);
    wr(3'd4, 16'h11); wr(3'd5, 16'h22);
    rd(3'd5, v); chk("R8 stage readback", {16'h0, v}, 16'h22);
    chk("R4 no output before tick", {16'h0, dacOut}, 0);

    sbq.push_back(16'h2211);
    wr(3'd0, 16'h3);
    wrEdge = cyc;
    waitIrq();
    chk("R2 first tick distance", lastIrqCyc - wrEdge, 20);
    tickRef = lastIrqCyc;
    chk("R5 irq on tick", {31'h0, irq}, 1);
    rd(3'd0, v); chk("R7 no underrun when fresh", {31'h0, v[2]}, 0);
    rd(3'd2, v); #1 chk("R6 ack clears irq", {31'h0, irq}, 0);

    wr(3'd4, 16'h33); wr(3'd5, 16'h44);
    chk("R4 stage write leaves output", {16'h0, dacOut}, 16'h2211);
    sbq.push_back(16'h4433);
    waitIrq();
    chk("R2 tick period", lastIrqCyc - tickRef, 20);
    tickRef = lastIrqCyc;

    rd(3'd2, v);
    wr(3'd4, 16'h55);
    sbq.push_back(16'h4455);
    waitIrq();
    tickRef = lastIrqCyc;
    rd(3'd0, v); chk("R7 underrun set", {31'h0, v[2]}, 1);
    chk("R7 stale channel retransferred", {24'h0, dacOut[15:8]}, 16'h44);
    rd(3'd2, v);
    wr(3'd0, 16'h3);
    rd(3'd0, v); chk("R7 write 0 keeps underrun", {31'h0, v[2]}, 1);
    wr(3'd0, 16'h7);
    rd(3'd0, v); chk("R7 write 1 clears underrun", {31'h0, v[2]}, 0);
    chk("R8 run and enable readback", {30'h0, v[1:0]}, 3);

    wr(3'd0, 16'h1);
    wr(3'd4, 16'h66); wr(3'd5, 16'h77);
    repeat (25) @(negedge clk);
    #1 chk("R5 masked irq low", {31'h0, irq}, 0);
    rd(3'd0, v); chk("R5 pending while masked", {31'h0, v[3]}, 1);
    chk("R3 both channels updated", {16'h0, dacOut}, 16'h7766);
    sbq.push_back(16'h7766);
    x = irqCount;
    wr(3'd0, 16'h3);
    #1 chk("R5 unmask raises irq", irqCount, x + 1);
    rd(3'd2, v);

    wr(3'd5, 16'h88);
    x = tickRef;
    while (x <= cyc + 1) x += 20;
    sbq.push_back(16'h8866);
    while (cyc != x - 1) @(negedge clk);
    addr = 3'd4; wrData = 16'h99; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
    #1 chk("R9 tick takes old stage value", {16'h0, dacOut}, 16'h8866);
    rd(3'd2, v);
    sbq.push_back(16'h8899);
    while (cyc != x + 19) @(negedge clk);
    addr = 3'd2; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    #1 chk("R6 tick wins over ack", {31'h0, irq}, 1);
    chk("R9 coincident write used next tick", {16'h0, dacOut}, 16'h8899);
    rd(3'd2, v);

    wr(3'd0, 16'h0);
    x = irqCount;
    repeat (50) @(negedge clk);
    #1 chk("R2 stopped timer no tick", irqCount, x);
    chk("R2 stopped output holds", {16'h0, dacOut}, 16'h8899);

    wr(3'd1, 16'd5);
    wr(3'd4, 16'hAB); wr(3'd5, 16'hCD);
    sbq.push_back(16'hCDAB);
    wr(3'd0, 16'h3);
    wrEdge = cyc;
    waitIrq();
    chk("R2 restart with divisor 5", lastIrqCyc - wrEdge, 5);
    wr(3'd0, 16'h0);
    rd(3'd2, v);
    chk("R3 scoreboard drained", sbq.size(), 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule